// File: doc/BRIEF.md
# Audio Sample FIFO Pair with Word Alignment

This block sits between a 32-bit host or DMA word port and a 24-bit audio sample path. It holds two first-in first-out queues. The transmit queue takes host words and turns each one into a 24-bit sample, using a selectable resolution (16, 20 or 24 bits) and a selectable alignment of the valid bits within the host word. The receive queue takes 24-bit samples from the line side and presents the oldest one to the host as a 32-bit word, packed in one of four ways.

Each queue reports its fill state as a word count and a one-bit flag. It raises a DMA request level against a programmable threshold. A one-cycle flush command empties it. Each queue also has a free-running 32-bit count of the samples it has accepted. Software can preload that count, and counting then continues from the loaded value. The storage depth is a parameter (default 32 entries, a power of two).

Top module: `audio_sample_fifo`

## Requirements
- R1: A transmit word becomes a 24-bit sample with the valid bits at the top and zeros below. `tx_res` selects the resolution: 0 = 16 bits, 1 = 20 bits, 2 or 3 = 24 bits. With `tx_in_mode` = 0 the valid bits are the top bits of the word (word[31:16], word[31:12] or word[31:8]). With `tx_in_mode` = 1 they are the low bits (word[15:0], word[19:0] or word[23:0]).
- R2: `rx_rdata` packs the oldest received sample s according to `rx_mode`:
  - 0 = {s[23:0], 8'h00}
  - 1 = s sign-extended to 32 bits
  - 2 = {s[23:8], 16'h0000}
  - 3 = s[23:8] sign-extended to 32 bits
- R3: Both queues keep arrival order. Alternate A/B channel samples come out A first, then B. `tx_sample` shows the oldest transmit entry.
- R4: A write to a full queue is discarded. A pop or read from an empty queue changes nothing.
- R5: `tx_free` gives the free transmit entries and `rx_level` the stored receive entries. `tx_room` is 1 when at least one transmit entry is free. `rx_avail` is 1 when at least one receive entry is stored.
- R6: `tx_drq` is 1 while `tx_free` >= `tx_trig`.
- R7: `rx_drq` is 1 while `rx_level` >= `rx_trig` + 1.
- R8: A one-cycle `flush_tx` or `flush_rx` empties its queue at the next edge. A write to that queue in the same cycle is discarded.
- R9: `tx_count` and `rx_count` rise by one for each accepted write. A load strobe sets the count to `cnt_ld_val`, taking priority over a same-cycle increment, and counting resumes from that value.
- R10: After reset both queues are empty and both counts are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr | input | 1 | Host writes a transmit word |
| tx_wdata | input | 32 | Transmit host word |
| tx_in_mode | input | 1 | 0 = valid bits at top of word, 1 = at bottom |
| tx_res | input | 2 | Transmit resolution select |
| tx_pop | input | 1 | Line side consumes the oldest transmit sample |
| tx_sample | output | 24 | Oldest transmit sample |
| rx_push | input | 1 | Line side delivers a receive sample |
| rx_sample | input | 24 | Receive sample |
| rx_rd | input | 1 | Host consumes the oldest receive word |
| rx_mode | input | 2 | Receive packing select |
| rx_rdata | output | 32 | Packed oldest receive sample |
| tx_trig | input | log2(DEPTH) | Transmit request threshold |
| rx_trig | input | log2(DEPTH) | Receive request threshold minus one |
| flush_tx | input | 1 | Empty the transmit queue |
| flush_rx | input | 1 | Empty the receive queue |
| tx_free | output | log2(DEPTH)+1 | Free transmit entries |
| rx_level | output | log2(DEPTH)+1 | Stored receive entries |
| tx_room | output | 1 | Transmit queue not full |
| rx_avail | output | 1 | Receive queue not empty |
| tx_drq | output | 1 | Transmit DMA request |
| rx_drq | output | 1 | Receive DMA request |
| tx_cnt_ld | input | 1 | Load the transmit count |
| rx_cnt_ld | input | 1 | Load the receive count |
| cnt_ld_val | input | 32 | Value for either count load |
| tx_count | output | 32 | Accepted transmit sample count |
| rx_count | output | 32 | Accepted receive sample count |

## Verification
The hardest situations to reach from the ports are the ones at the edges of a full queue. These are a write arriving while the queue is full and a pop is also requested, a flush coinciding with a write, and a count load coinciding with an accepted write. Random traffic alone seldom holds a queue full long enough to hit them. The stimulus therefore runs alternating fill-biased and drain-biased random phases, so both queues repeatedly reach full and empty. Directed steps then force the flush and load collisions explicitly and sweep every alignment and packing mode with a negative sample.

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_wr,
  input  logic [31:0]   tx_wdata,
  input  logic          tx_in_mode,
  input  logic [1:0]    tx_res,
  input  logic          tx_pop,
  output logic [23:0]   tx_sample,
  input  logic          rx_push,
  input  logic [23:0]   rx_sample,
  input  logic          rx_rd,
  input  logic [1:0]    rx_mode,
  output logic [31:0]   rx_rdata,
  input  logic [AW-1:0] tx_trig,
  input  logic [AW-1:0] rx_trig,
  input  logic          flush_tx,
  input  logic          flush_rx,
  output logic [CW-1:0] tx_free,
  output logic [CW-1:0] rx_level,
  output logic          tx_room,
  output logic          rx_avail,
  output logic          tx_drq,
  output logic          rx_drq,
  input  logic          tx_cnt_ld,
  input  logic          rx_cnt_ld,
  input  logic [31:0]   cnt_ld_val,
  output logic [31:0]   tx_count,
  output logic [31:0]   rx_count
);

  logic [23:0]   tx_mem [DEPTH];
  logic [23:0]   rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;
  logic [CW-1:0] tx_lvl;
  logic [23:0]   tx_aligned, rx_head;

  wire tx_full  = (tx_lvl == CW'(DEPTH));
  wire rx_full  = (rx_level == CW'(DEPTH));
  wire tx_wr_ok = tx_wr && !tx_full && !flush_tx;
  wire tx_pop_ok = tx_pop && (tx_lvl != '0) && !flush_tx;
  wire rx_wr_ok = rx_push && !rx_full && !flush_rx;
  wire rx_rd_ok = rx_rd && (rx_level != '0) && !flush_rx;

  always_comb begin
    unique case ({tx_in_mode, tx_res})
      3'b000:  tx_aligned = {tx_wdata[31:16], 8'h00};
      3'b001:  tx_aligned = {tx_wdata[31:12], 4'h0};
      3'b100:  tx_aligned = {tx_wdata[15:0], 8'h00};
      3'b101:  tx_aligned = {tx_wdata[19:0], 4'h0};
      3'b010, 3'b011: tx_aligned = tx_wdata[31:8];
      default: tx_aligned = tx_wdata[23:0];
    endcase
  end

  always_ff @(posedge clk) begin
    if (tx_wr_ok) tx_mem[tx_wp] <= tx_aligned;
    if (rx_wr_ok) rx_mem[rx_wp] <= rx_sample;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp <= '0; tx_rp <= '0; tx_lvl <= '0;
    end else if (flush_tx) begin
      tx_wp <= '0; tx_rp <= '0; tx_lvl <= '0;
    end else begin
      if (tx_wr_ok)  tx_wp <= tx_wp + AW'(1);
      if (tx_pop_ok) tx_rp <= tx_rp + AW'(1);
      tx_lvl <= tx_lvl + CW'(tx_wr_ok) - CW'(tx_pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp <= '0; rx_rp <= '0; rx_level <= '0;
    end else if (flush_rx) begin
      rx_wp <= '0; rx_rp <= '0; rx_level <= '0;
    end else begin
      if (rx_wr_ok) rx_wp <= rx_wp + AW'(1);
      if (rx_rd_ok) rx_rp <= rx_rp + AW'(1);
      rx_level <= rx_level + CW'(rx_wr_ok) - CW'(rx_rd_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_count <= '0;
      rx_count <= '0;
    end else begin
      if (tx_cnt_ld)     tx_count <= cnt_ld_val;
      else if (tx_wr_ok) tx_count <= tx_count + 32'd1;
      if (rx_cnt_ld)     rx_count <= cnt_ld_val;
      else if (rx_wr_ok) rx_count <= rx_count + 32'd1;
    end
  end

  assign tx_sample = tx_mem[tx_rp];
  assign rx_head   = rx_mem[rx_rp];

  always_comb begin
    unique case (rx_mode)
      2'd0:    rx_rdata = {rx_head, 8'h00};
      2'd1:    rx_rdata = {{8{rx_head[23]}}, rx_head};
      2'd2:    rx_rdata = {rx_head[23:8], 16'h0000};
      default: rx_rdata = {{16{rx_head[23]}}, rx_head[23:8]};
    endcase
  end

  assign tx_free  = CW'(DEPTH) - tx_lvl;
  assign tx_room  = !tx_full;
  assign rx_avail = (rx_level != '0);
  assign tx_drq   = (tx_free >= CW'(tx_trig));
  assign rx_drq   = (rx_level >= (CW'(rx_trig) + CW'(1)));

endmodule

// File: rtl/audio_sample_fifo_chk.sv
module audio_sample_fifo_chk #(
  parameter int DEPTH = 32,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_wr,
  input logic          tx_pop,
  input logic          flush_tx,
  input logic          flush_rx,
  input logic [1:0]    rx_mode,
  input logic [31:0]   rx_rdata,
  input logic [CW-1:0] tx_free,
  input logic [CW-1:0] rx_level,
  input logic          rx_drq,
  input logic          tx_cnt_ld,
  input logic [31:0]   cnt_ld_val,
  input logic [31:0]   tx_count
);

  AST_TX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush_tx |=> tx_free == CW'(DEPTH)); // R8
  AST_RX_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n) flush_rx |=> rx_level == '0); // R8
  AST_TX_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (tx_free == '0 && tx_wr && !tx_pop && !flush_tx) |=> tx_free == '0); // R4
  AST_RX_DRQ_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n) rx_drq |-> rx_level != '0); // R7
  AST_RX_SIGN_FILL: assert property (@(posedge clk) disable iff (!rst_n) (rx_mode == 2'd1 && rx_level != '0) |-> rx_rdata[31:24] == {8{rx_rdata[23]}}); // R2
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt_ld |=> tx_count == $past(cnt_ld_val)); // R9
  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (!tx_cnt_ld && !flush_tx && tx_wr && tx_free != '0) |=> tx_count == $past(tx_count) + 32'd1); // R9

endmodule

bind audio_sample_fifo audio_sample_fifo_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_wr(tx_wr), .tx_pop(tx_pop),
  .flush_tx(flush_tx), .flush_rx(flush_rx), .rx_mode(rx_mode),
  .rx_rdata(rx_rdata), .tx_free(tx_free), .rx_level(rx_level),
  .rx_drq(rx_drq), .tx_cnt_ld(tx_cnt_ld), .cnt_ld_val(cnt_ld_val),
  .tx_count(tx_count)
);

// File: tb/audio_sample_fifo_test.sv
`timescale 1ns/1ps
module audio_sample_fifo_test;
  localparam int DEPTH = 32;
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic clk = 0, rst_n = 0;
  logic tx_wr = 0, tx_in_mode = 0, tx_pop = 0, rx_push = 0, rx_rd = 0;
  logic [31:0] tx_wdata = 0, cnt_ld_val = 0;
  logic [1:0] tx_res = 0, rx_mode = 0;
  logic [23:0] rx_sample = 0, tx_sample;
  logic [31:0] rx_rdata, tx_count, rx_count;
  logic [AW-1:0] tx_trig = 0, rx_trig = 0;
  logic flush_tx = 0, flush_rx = 0, tx_cnt_ld = 0, rx_cnt_ld = 0;
  logic [CW-1:0] tx_free, rx_level;
  logic tx_room, rx_avail, tx_drq, rx_drq;

  int checks = 0, fails = 0;
  logic [23:0] txq[$], rxq[$];
  logic [31:0] m_txc = 0, m_rxc = 0;

  always #2.5 clk = ~clk;

  audio_sample_fifo #(.DEPTH(DEPTH)) uut (.*);

  function automatic logic [23:0] align(logic [31:0] w, logic m, logic [1:0] r);
    int bits = (r == 0) ? 16 : (r == 1) ? 20 : 24;
    logic [31:0] v = m ? (w & ((32'd1 << bits) - 1)) : (w >> (32 - bits));
    return 24'(v << (24 - bits));
  endfunction

  function automatic logic [31:0] pack(logic [23:0] s, logic [1:0] m);
    logic [31:0] sx = {{8{s[23]}}, s};
    case (m)
      2'd0: return {s, 8'h00};
      2'd1: return sx;
      2'd2: return {s[23:8], 16'h0};
      default: return $signed(sx) >>> 8;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic compare();
    int tf = DEPTH - txq.size();
    int rl = rxq.size();
    chk("R5 tx_free", 32'(tx_free), 32'(tf));
    chk("R5 rx_level", 32'(rx_level), 32'(rl));
    chk("R5 tx_room", 32'(tx_room), 32'(tf != 0));
    chk("R5 rx_avail", 32'(rx_avail), 32'(rl != 0));
    chk("R6 tx_drq", 32'(tx_drq), 32'(tf >= int'(tx_trig)));
    chk("R7 rx_drq", 32'(rx_drq), 32'(rl >= int'(rx_trig) + 1));
    chk("R9 tx_count", tx_count, m_txc);
    chk("R9 rx_count", rx_count, m_rxc);
    if (txq.size() != 0) chk("R1 R3 tx_sample", 32'(tx_sample), 32'(txq[0]));
    if (rxq.size() != 0) chk("R2 R3 rx_rdata", rx_rdata, pack(rxq[0], rx_mode));
  endtask

  task automatic step();
    @(posedge clk);
    if (flush_tx) txq.delete();
    else begin
      bit wok = tx_wr && txq.size() < DEPTH;
      if (tx_pop && txq.size() != 0) void'(txq.pop_front());
      if (wok) txq.push_back(align(tx_wdata, tx_in_mode, tx_res));
      if (!tx_cnt_ld && wok) m_txc++;
    end
    if (tx_cnt_ld) m_txc = cnt_ld_val;
    if (flush_rx) rxq.delete();
    else begin
      bit wok = rx_push && rxq.size() < DEPTH;
      if (rx_rd && rxq.size() != 0) void'(rxq.pop_front());
      if (wok) rxq.push_back(rx_sample);
      if (!rx_cnt_ld && wok) m_rxc++;
    end
    if (rx_cnt_ld) m_rxc = cnt_ld_val;
    @(negedge clk);
    compare();
    {tx_wr, tx_pop, rx_push, rx_rd, flush_tx, flush_rx, tx_cnt_ld, rx_cnt_ld} = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int dummy = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R10 reset state
    chk("R10 tx_free", 32'(tx_free), DEPTH);
    chk("R10 rx_level", 32'(rx_level), 0);
    chk("R10 tx_count", tx_count, 0);
    chk("R10 rx_count", rx_count, 0);

    // R1 every alignment and resolution
    for (int m = 0; m < 2; m++)
      for (int r = 0; r < 4; r++) begin
        tx_in_mode = 1'(m); tx_res = 2'(r);
        tx_wdata = 32'hABCD_E123; tx_wr = 1; step();
        chk("R1 aligned", 32'(tx_sample), 32'(align(32'hABCD_E123, 1'(m), 2'(r))));
        tx_pop = 1; step();
      end

    // R2 R3 channel A then B, all packings
    rx_sample = 24'h812345; rx_push = 1; step();
    rx_sample = 24'h7F00AA; rx_push = 1; step();
    for (int m = 0; m < 4; m++) begin rx_mode = 2'(m); step(); end
    chk("R2 mode3 A", pack(24'h812345, 2'd3), 32'hFFFF8123);
    rx_rd = 1; step();
    for (int m = 0; m < 4; m++) begin rx_mode = 2'(m); step(); end
    rx_rd = 1; step();
    rx_rd = 1; step();   // R4 read from empty

    // R4 fill beyond full, write+pop on full
    for (int i = 0; i < DEPTH + 3; i++) begin tx_wdata = 32'(i * 7919); tx_wr = 1; step(); end
    chk("R4 full", 32'(tx_free), 0);
    tx_wr = 1; tx_pop = 1; step();
    // R8 flush with write in the same cycle
    tx_wr = 1; flush_tx = 1; rx_push = 1; flush_rx = 1; step();
    chk("R8 flushed", 32'(tx_free), DEPTH);
    // R9 load collides with accepted write
    cnt_ld_val = 32'hFFFF_FFFE; tx_cnt_ld = 1; rx_cnt_ld = 1; tx_wr = 1; rx_push = 1; step();
    tx_wr = 1; rx_push = 1; step();
    tx_wr = 1; rx_push = 1; step();
    chk("R9 wrap", tx_count, 0);

    // random phases biased to fill, then drain
    for (int ph = 0; ph < 12; ph++)
      for (int i = 0; i < 250; i++) begin
        bit fill = (ph % 2 == 0);
        tx_wr = fill ? ($urandom % 4 != 0) : ($urandom % 4 == 0);
        tx_pop = fill ? ($urandom % 4 == 0) : ($urandom % 4 != 0);
        rx_push = tx_wr ^ ($urandom % 8 == 0);
        rx_rd = tx_pop ^ ($urandom % 8 == 0);
        tx_wdata = $urandom; rx_sample = 24'($urandom);
        tx_in_mode = 1'($urandom); tx_res = 2'($urandom); rx_mode = 2'($urandom);
        tx_trig = AW'($urandom); rx_trig = AW'($urandom);
        flush_tx = ($urandom % 200 == 0); flush_rx = ($urandom % 200 == 0);
        tx_cnt_ld = ($urandom % 150 == 0); rx_cnt_ld = ($urandom % 150 == 0);
        cnt_ld_val = $urandom;
        step();
      end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule